// File: doc/BRIEF.md
# Byte-Lane Access Qualifier

This block sits between a bus target and the local functions behind it. The target has already claimed an I/O or memory data phase. The block then decides whether that phase is allowed to reach the addressed function. It also picks the one live byte lane for byte-wide regions, forms the local address, and steers read data back onto the right lane of the 32-bit bus.

Byte-wide regions hold one register per address. In I/O space the registers are packed. In memory space each register takes a whole DWORD, and a lane-select field decides which byte of that DWORD is live, so a big-endian host needs no software swapping. Regions of 32-bit width pass any byte-enable pattern through as a write mask. An access that fails qualification still completes on the bus, but it raises no strobe and returns zero data.

Each request is a one-cycle pulse. The qualified strobe and the local address and data follow one cycle later. The local function answers on `loc_rdata` during the strobe cycle, and the completion with the bus read data follows one cycle after that.

Top module: `blq_access_qualifier`

## Requirements
- R1: While reset is held and after it is released, `acc_stb` and `rsp_done` are 0, `loc_be` is 0 and `rsp_rdata` is zero. A request in flight when reset is asserted produces no completion.
- R2: For an I/O access (`req_mem`=0) to a byte-wide region (`req_wide`=0), the access qualifies only if `req_be_n` equals the active-low one-hot of `req_addr[1:0]`. 00 needs 1110, 01 needs 1101, 10 needs 1011 and 11 needs 0111.
- R3: For a memory access (`req_mem`=1) to a byte-wide region, the access qualifies only if `req_be_n` equals the active-low one-hot of `lane_cfg`. Address bits [1:0] play no part.
- R4: A byte-wide access whose byte enables assert zero lanes, or more than one lane, never qualifies.
- R5: `loc_addr` equals `req_addr` for I/O byte-wide accesses. For memory byte-wide accesses and for all 32-bit-region accesses it equals `req_addr` shifted right by two, which is the DWORD index.
- R6: `loc_wbyte` is the write-data byte on the live lane. That lane is `req_addr[1:0]` for I/O byte-wide accesses and `lane_cfg` for memory byte-wide accesses. For 32-bit regions it is lane 0 (bits 7:0).
- R7: A 32-bit-region access qualifies for every byte-enable pattern, including none. `loc_be` is then the active-high inverse of `req_be_n`, so disabled bytes are marked unchanged. For byte-wide accesses `loc_be` is the one-hot of the live lane.
- R8: A qualified byte-wide read places `loc_rdata[7:0]` on the live lane of `rsp_rdata` and drives every other lane with zero.
- R9: A qualified 32-bit-region read returns `loc_rdata` on enabled lanes and zero on disabled lanes.
- R10: An access that does not qualify raises no `acc_stb`, still produces `rsp_done`, and returns all-zero `rsp_rdata`. Writes also return zero data.
- R11: `acc_stb` (with `acc_write`, `loc_addr`, `loc_be`, `loc_wbyte`, `loc_wdata`) is valid in the cycle after a qualified `req_valid` and lasts one cycle per request. `rsp_done` follows one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle pulse per claimed data phase |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wide | input | 1 | 1 = 32-bit region, 0 = byte-wide region |
| req_addr | input | ADDR_W | Bus byte address |
| req_be_n | input | LANES | Active-low byte enables |
| req_wdata | input | 8*LANES | Bus write data |
| lane_cfg | input | log2(LANES) | Live lane for memory byte-wide regions |
| acc_stb | output | 1 | Qualified access strobe |
| acc_write | output | 1 | Direction of the strobed access |
| loc_addr | output | ADDR_W | Local register address |
| loc_be | output | LANES | Active-high byte mask for the local side |
| loc_wbyte | output | 8 | Write byte for byte-wide functions |
| loc_wdata | output | 8*LANES | Full write data for 32-bit functions |
| loc_rdata | input | 8*LANES | Local read data, sampled in the strobe cycle |
| rsp_done | output | 1 | Completion pulse for every request |
| rsp_rdata | output | 8*LANES | Read data steered onto bus lanes |

## Verification
A wrong lane decode shows up at the ports one cycle after the request. It appears either as a strobe that fires or stays quiet against the rule for that space, or as a `loc_be` pattern that is not the expected one-hot. A wrong address shift shows on `loc_addr` in that same cycle. Faults in the read steering or in the registered qualification flag reach `rsp_rdata` one cycle later, as a byte on the wrong lane or stale bits that are not zero. Each vector pairs a matching and a mismatching enable pattern in both spaces, so every such fault is exposed within two cycles of its request.

// File: rtl/blq_pkg.sv
package blq_pkg;
   typedef enum logic {
      SPACE_IO  = 1'b0,
      SPACE_MEM = 1'b1
   } space_e;

   typedef enum logic {
      REGION_BYTE = 1'b0,
      REGION_WIDE = 1'b1
   } region_e;
endpackage

// File: rtl/blq_lane_decode.sv
module blq_lane_decode #(
   parameter int LANES = 4
) (
   input  blq_pkg::space_e           space,
   input  blq_pkg::region_e          region,
   input  logic [$clog2(LANES)-1:0]  addr_lane,
   input  logic [$clog2(LANES)-1:0]  lane_cfg,
   input  logic [LANES-1:0]          be_n,
   output logic [$clog2(LANES)-1:0]  live_lane,
   output logic [LANES-1:0]          lane_mask,
   output logic                      qualified
);
   import blq_pkg::*;

   localparam int LW = $clog2(LANES);

   logic [LANES-1:0] be;
   logic [LANES-1:0] expect_oh;
   logic [LANES-1:0] lane_hit;
   logic             byte_ok;

   assign be = ~be_n;

   always_comb begin
      if (region == REGION_WIDE)
         live_lane = '0;
      else if (space == SPACE_MEM)
         live_lane = lane_cfg;
      else
         live_lane = addr_lane;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign expect_oh[g] = (live_lane == LW'(g));
      assign lane_hit[g]  = (be[g] == expect_oh[g]);
   end

   assign byte_ok   = &lane_hit;
   assign qualified = (region == REGION_WIDE) || byte_ok;
   assign lane_mask = (region == REGION_WIDE) ? be : expect_oh;

   always_comb begin
      if (region == REGION_BYTE && qualified)
         p_byte_single_enable_r4: assert ($countones(be_n) == LANES - 1);
   end
endmodule

// File: rtl/blq_addr_map.sv
module blq_addr_map #(
   parameter int ADDR_W = 16,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  blq_pkg::space_e   space,
   input  blq_pkg::region_e  region,
   output logic [ADDR_W-1:0] loc_addr
);
   import blq_pkg::*;

   localparam int SHIFT = $clog2(LANES);

   if (ADDR_W <= SHIFT) begin : g_bad_addr_w
      $error("ADDR_W must exceed the lane index width");
   end

   logic [ADDR_W-1:0] dword_idx;
   logic              packed_map;

   assign dword_idx  = bus_addr >> SHIFT;
   assign packed_map = (space == SPACE_IO) && (region == REGION_BYTE);
   assign loc_addr   = packed_map ? bus_addr : dword_idx;
endmodule

// File: rtl/blq_wr_pick.sv
module blq_wr_pick #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0]        wdata,
   input  logic [$clog2(LANES)-1:0]  live_lane,
   output logic [7:0]                wr_byte
);
   localparam int LW = $clog2(LANES);

   always_comb begin
      wr_byte = '0;
      for (int i = 0; i < LANES; i++) begin
         if (live_lane == LW'(i))
            wr_byte = wdata[8*i +: 8];
      end
   end
endmodule

// File: rtl/blq_rd_place.sv
module blq_rd_place #(
   parameter int LANES        = 4,
   parameter bit WIDE_RD_ZERO = 1'b1
) (
   input  blq_pkg::region_e   region,
   input  logic [LANES-1:0]   lane_mask,
   input  logic [8*LANES-1:0] loc_rdata,
   output logic [8*LANES-1:0] rd_bus
);
   import blq_pkg::*;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] byte_val;
      logic [7:0] wide_val;

      assign byte_val = lane_mask[g] ? loc_rdata[7:0] : 8'h00;

      if (WIDE_RD_ZERO) begin : g_mask
         assign wide_val = lane_mask[g] ? loc_rdata[8*g +: 8] : 8'h00;
      end else begin : g_pass
         assign wide_val = loc_rdata[8*g +: 8];
      end

      assign rd_bus[8*g +: 8] = (region == REGION_WIDE) ? wide_val : byte_val;
   end
endmodule

// File: rtl/blq_access_qualifier.sv
module blq_access_qualifier #(
   parameter int ADDR_W       = 16,
   parameter int LANES        = 4,
   parameter bit WIDE_RD_ZERO = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic                      req_mem,
   input  logic                      req_wide,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LANES-1:0]          req_be_n,
   input  logic [8*LANES-1:0]        req_wdata,
   input  logic [$clog2(LANES)-1:0]  lane_cfg,
   output logic                      acc_stb,
   output logic                      acc_write,
   output logic [ADDR_W-1:0]         loc_addr,
   output logic [LANES-1:0]          loc_be,
   output logic [7:0]                loc_wbyte,
   output logic [8*LANES-1:0]        loc_wdata,
   input  logic [8*LANES-1:0]        loc_rdata,
   output logic                      rsp_done,
   output logic [8*LANES-1:0]        rsp_rdata
);
   import blq_pkg::*;

   localparam int LW     = $clog2(LANES);
   localparam int DATA_W = 8 * LANES;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two and at least 2");
   end

   // request decode
   space_e            space_in;
   region_e           region_in;
   logic [LW-1:0]     live_lane;
   logic [LANES-1:0]  lane_mask;
   logic              qualified;
   logic [ADDR_W-1:0] addr_mapped;
   logic [7:0]        wr_byte;

   assign space_in  = req_mem  ? SPACE_MEM   : SPACE_IO;
   assign region_in = req_wide ? REGION_WIDE : REGION_BYTE;

   blq_lane_decode #(.LANES(LANES)) u_decode (
      .space     (space_in),
      .region    (region_in),
      .addr_lane (req_addr[LW-1:0]),
      .lane_cfg  (lane_cfg),
      .be_n      (req_be_n),
      .live_lane (live_lane),
      .lane_mask (lane_mask),
      .qualified (qualified)
   );

   blq_addr_map #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
      .bus_addr (req_addr),
      .space    (space_in),
      .region   (region_in),
      .loc_addr (addr_mapped)
   );

   blq_wr_pick #(.LANES(LANES)) u_wr (
      .wdata     (req_wdata),
      .live_lane (live_lane),
      .wr_byte   (wr_byte)
   );

   // stage 1: local side
   logic    s1_valid;
   logic    s1_qual;
   region_e s1_region;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_qual   <= 1'b0;
         s1_region <= REGION_BYTE;
         acc_stb   <= 1'b0;
         acc_write <= 1'b0;
         loc_addr  <= '0;
         loc_be    <= '0;
         loc_wbyte <= '0;
         loc_wdata <= '0;
      end else begin
         s1_valid <= req_valid;
         acc_stb  <= req_valid && qualified;
         if (req_valid) begin
            s1_qual   <= qualified;
            s1_region <= region_in;
            acc_write <= req_write;
            loc_addr  <= addr_mapped;
            loc_be    <= lane_mask;
            loc_wbyte <= wr_byte;
            loc_wdata <= req_wdata;
         end
      end
   end

   // stage 2: bus response
   logic [DATA_W-1:0] rd_bus;

   blq_rd_place #(.LANES(LANES), .WIDE_RD_ZERO(WIDE_RD_ZERO)) u_rd (
      .region    (s1_region),
      .lane_mask (loc_be),
      .loc_rdata (loc_rdata),
      .rd_bus    (rd_bus)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done  <= s1_valid;
         if (s1_valid)
            rsp_rdata <= (s1_qual && !acc_write) ? rd_bus : '0;
      end
   end

   // checks
   p_stb_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stb |-> $past(req_valid));

   p_dir_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stb |-> acc_write == $past(req_write));

   p_done_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(req_valid, 2));

   p_unqual_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !$past(acc_stb)) |-> rsp_rdata == '0);

   p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && s1_region == REGION_BYTE) |-> $countones(loc_be) == 1);
endmodule

// File: tb/tb_blq_access_qualifier.sv
`timescale 1ns/1ps
module tb_blq_access_qualifier;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_mem = 1'b0;
   logic        req_wide = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_be_n = 4'hF;
   logic [31:0] req_wdata = '0;
   logic [1:0]  lane_cfg = '0;
   logic        acc_stb, acc_write;
   logic [15:0] loc_addr;
   logic [3:0]  loc_be;
   logic [7:0]  loc_wbyte;
   logic [31:0] loc_wdata;
   logic [31:0] loc_rdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   blq_access_qualifier dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mem(req_mem), .req_wide(req_wide), .req_addr(req_addr),
      .req_be_n(req_be_n), .req_wdata(req_wdata), .lane_cfg(lane_cfg),
      .acc_stb(acc_stb), .acc_write(acc_write), .loc_addr(loc_addr),
      .loc_be(loc_be), .loc_wbyte(loc_wbyte), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   typedef struct packed {
      logic        wr, mem, wide;
      logic [15:0] addr;
      logic [3:0]  be_n;
      logic [31:0] wdata;
      logic [1:0]  sel;
      logic [31:0] lrd;
      logic        exp_stb;
      logic [15:0] exp_addr;
      logic [3:0]  exp_be;
      logic [7:0]  exp_wbyte;
      logic [31:0] exp_rd;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,16'h0012,4'b1011,32'hAABBCCDD,2'd0,32'h0,       1'b1,16'h0012,4'b0100,8'hBB,32'h0},
      '{1'b1,1'b0,1'b0,16'h0013,4'b0111,32'h11223344,2'd0,32'h0,       1'b1,16'h0013,4'b1000,8'h11,32'h0},
      '{1'b1,1'b0,1'b0,16'h0010,4'b1101,32'h55667788,2'd0,32'h0,       1'b0,16'h0000,4'b0000,8'h00,32'h0},
      '{1'b0,1'b0,1'b0,16'h0021,4'b1101,32'h0,       2'd0,32'h123456A5,1'b1,16'h0021,4'b0010,8'h00,32'h0000A500},
      '{1'b0,1'b0,1'b0,16'h0020,4'b1100,32'h0,       2'd0,32'h000000A5,1'b0,16'h0000,4'b0000,8'h00,32'h0},
      '{1'b1,1'b1,1'b0,16'h0104,4'b0111,32'h5A000000,2'd3,32'h0,       1'b1,16'h0041,4'b1000,8'h5A,32'h0},
      '{1'b1,1'b1,1'b0,16'h0108,4'b1110,32'h000000C3,2'd0,32'h0,       1'b1,16'h0042,4'b0001,8'hC3,32'h0},
      '{1'b1,1'b1,1'b0,16'h0103,4'b0111,32'hFF000000,2'd0,32'h0,       1'b0,16'h0000,4'b0000,8'h00,32'h0},
      '{1'b0,1'b1,1'b0,16'h0200,4'b1101,32'h0,       2'd1,32'hFFFFFF7E,1'b1,16'h0080,4'b0010,8'h00,32'h00007E00},
      '{1'b0,1'b1,1'b0,16'h0204,4'b1111,32'h0,       2'd2,32'h00000077,1'b0,16'h0000,4'b0000,8'h00,32'h0},
      '{1'b1,1'b1,1'b1,16'h0304,4'b0101,32'hDEADBEEF,2'd0,32'h0,       1'b1,16'h00C1,4'b1010,8'hEF,32'h0},
      '{1'b0,1'b1,1'b1,16'h0308,4'b0011,32'h0,       2'd0,32'h12345678,1'b1,16'h00C2,4'b1100,8'h00,32'h12340000},
      '{1'b1,1'b0,1'b1,16'h0010,4'b1111,32'h0,       2'd0,32'h0,       1'b1,16'h0004,4'b0000,8'h00,32'h0},
      '{1'b0,1'b0,1'b1,16'h0044,4'b0000,32'h0,       2'd0,32'hCAFEF00D,1'b1,16'h0011,4'b1111,8'h00,32'hCAFEF00D},
      '{1'b0,1'b1,1'b0,16'h0000,4'b0111,32'h0,       2'd3,32'h00000099,1'b1,16'h0000,4'b1000,8'h00,32'h99000000}
   };

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string gate_tag(input vec_t v);
      if (v.wide) return "R7";
      if ($countones(~v.be_n) != 1) return "R4";
      if (v.mem) return "R3";
      return "R2";
   endfunction

   function automatic string rd_tag(input vec_t v);
      if (!v.exp_stb || v.wr) return "R10";
      if (v.wide) return "R9";
      return "R8";
   endfunction

   task automatic drive(input vec_t v);
      req_valid = 1'b1;
      req_write = v.wr;
      req_mem   = v.mem;
      req_wide  = v.wide;
      req_addr  = v.addr;
      req_be_n  = v.be_n;
      req_wdata = v.wdata;
      lane_cfg  = v.sel;
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      drive(v);
      @(negedge clk);
      req_valid = 1'b0;
      loc_rdata = v.lrd;
      chk(gate_tag(v), "acc_stb", 32'(acc_stb), 32'(v.exp_stb));
      if (v.exp_stb) begin
         chk("R5", "loc_addr", 32'(loc_addr), 32'(v.exp_addr));
         chk("R7", "loc_be", 32'(loc_be), 32'(v.exp_be));
         chk("R11", "acc_write", 32'(acc_write), 32'(v.wr));
         if (v.wr) chk("R6", "loc_wbyte", 32'(loc_wbyte), 32'(v.exp_wbyte));
      end
      @(negedge clk);
      chk("R11", "acc_stb single pulse", 32'(acc_stb), 32'h0);
      chk("R10", "rsp_done", 32'(rsp_done), 32'h1);
      chk(rd_tag(v), "rsp_rdata", rsp_rdata, v.exp_rd);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "acc_stb in reset", 32'(acc_stb), 32'h0);
      chk("R1", "rsp_done in reset", 32'(rsp_done), 32'h0);
      chk("R1", "rsp_rdata in reset", rsp_rdata, 32'h0);
      chk("R1", "loc_be in reset", 32'(loc_be), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "acc_stb after release", 32'(acc_stb), 32'h0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: back-to-back requests give one strobe each
      @(negedge clk);
      drive(VECS[0]);
      @(negedge clk);
      drive(VECS[5]);
      chk("R11", "b2b first stb", 32'(acc_stb), 32'h1);
      chk("R5", "b2b first addr", 32'(loc_addr), 32'h0012);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11", "b2b second stb", 32'(acc_stb), 32'h1);
      chk("R5", "b2b second addr", 32'(loc_addr), 32'h0041);
      chk("R11", "b2b first done", 32'(rsp_done), 32'h1);
      @(negedge clk);
      chk("R11", "b2b stb ends", 32'(acc_stb), 32'h0);
      chk("R11", "b2b second done", 32'(rsp_done), 32'h1);
      @(negedge clk);
      chk("R11", "done ends", 32'(rsp_done), 32'h0);

      // R1: reset drops a request in flight
      drive(VECS[3]);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R1", "stb cleared by reset", 32'(acc_stb), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "no done after reset", 32'(rsp_done), 32'h0);
      chk("R1", "rdata cleared", rsp_rdata, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule